// File: doc/BRIEF.md
# Sixteen-Line GPIO Controller with Per-Line Interrupt Detection

The block drives and samples sixteen general-purpose pins through a small word-addressed register interface. Each pin can be an input or an output. Every pin is also watched by its own event detector, which can respond to a high level, a low level, a rising edge, a falling edge or any transition. Each detected event sets a sticky status bit, and that status bit is presented directly as the pin's own interrupt output.

Software sets the direction and output data registers. It reads the synchronized pin levels from an input register. It chooses a detection style per pin through two style registers that hold 3-bit fields, and it acknowledges events by writing ones to the status register. Under a level style, the status bit sets again on every cycle that the level holds, so it cannot be cleared until the pin leaves the active level. Register reads return data one cycle after the request.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset every pin is an input (`pin_oe_o` all 0), the output data is 0, all style fields hold code 7 (disabled), and the status and `irq_o` are 0.
- R2: Word 0 is the direction register. A 1 in bit i makes pin i an input, and a 0 sets `pin_oe_o[i]`. Word 1 is the output data register and drives `pin_o`. Both registers read back what was written.
- R3: Word 2 returns the pin levels through a two-flop synchronizer. A read sampled on the third rising edge after a pin change, or later, returns the new level. A read sampled on the second edge or earlier returns the old level.
- R4: Style code 2 (rising) sets status on a 0-to-1 change of the synchronized level, on the third rising edge after the pin change. A falling change does not set it.
- R5: Style code 3 (falling) sets status on a 1-to-0 change only.
- R6: Style code 4 (transitional) sets status on both edges.
- R7: Style code 0 (active high) sets status on every cycle the synchronized level is 1. A clear written while the level is 1 has no effect. Once the level is 0, the clear takes effect.
- R8: Style code 1 (active low) behaves like R7 with the level inverted.
- R9: Word 4 holds the 3-bit fields for pins 0 to 7, and word 5 holds them for pins 8 to 15. Pin i uses bits [3k+2:3k], where k = i mod 8. Codes 5, 6 and 7 never set status.
- R10: Word 3 is the status register. Writing 1 to a bit clears it, and writing 0 leaves it unchanged. Reads return the current status.
- R11: When an event and a clear reach the same status bit in the same cycle, the bit ends up set.
- R12: `irq_o[i]` equals status bit i. An `irq_o` bit only rises on the cycle after its line detected an event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 3 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid one cycle after a read request |
| pin_i | input | 16 | Pin levels from the pads |
| pin_o | output | 16 | Output data to the pads |
| pin_oe_o | output | 16 | Output enable, 1 = drive |
| irq_o | output | 16 | Per-pin interrupt (status bit) |

## Verification
A pin change reaches the synchronized level after two rising edges, and any event status appears after the third. The bench therefore drives pins at a falling edge and checks `irq_o` after exactly two falling edges (expecting no change) and after three (expecting the change). Register writes take effect at the edge that samples the request, and read data appears one edge later. The read task samples at the falling edge after that edge. The same-cycle race is set up by aligning the clearing write's sampling edge with the third edge after a rising pin change.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned STYLE_W       = 3;
  localparam int unsigned LINES_PER_REG = 8;

  typedef enum logic [STYLE_W-1:0] {
    STY_HIGH = 3'd0,
    STY_LOW  = 3'd1,
    STY_RISE = 3'd2,
    STY_FALL = 3'd3,
    STY_BOTH = 3'd4
  } style_e;

  localparam logic [STYLE_W-1:0] STY_OFF = 3'd7;

  localparam int unsigned ADDR_DIR      = 0;
  localparam int unsigned ADDR_OUT      = 1;
  localparam int unsigned ADDR_IN       = 2;
  localparam int unsigned ADDR_STAT     = 3;
  localparam int unsigned ADDR_STY_BASE = 4;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH  = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) chain_q[s] <= '0;
    end else begin
      chain_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_detect.sv
module gpio_detect
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_LINES = 16
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [NUM_LINES-1:0]           lvl_i,
  input  logic [NUM_LINES*STYLE_W-1:0]   style_i,
  output logic [NUM_LINES-1:0]           ev_o
);
  logic [NUM_LINES-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= lvl_i;
  end

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    logic [STYLE_W-1:0] sty;
    assign sty = style_i[i*STYLE_W +: STYLE_W];
    always_comb begin
      case (sty)
        STY_HIGH: ev_o[i] = lvl_i[i];
        STY_LOW:  ev_o[i] = ~lvl_i[i];
        STY_RISE: ev_o[i] = lvl_i[i] & ~prev_q[i];
        STY_FALL: ev_o[i] = ~lvl_i[i] & prev_q[i];
        STY_BOTH: ev_o[i] = lvl_i[i] ^ prev_q[i];
        default:  ev_o[i] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_LINES = 16,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 3
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         req_i,
  input  logic                         we_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [DATA_W-1:0]            wdata_i,
  output logic [DATA_W-1:0]            rdata_o,
  input  logic [NUM_LINES-1:0]         lvl_i,
  input  logic [NUM_LINES-1:0]         ev_i,
  output logic [NUM_LINES-1:0]         dir_o,
  output logic [NUM_LINES-1:0]         out_o,
  output logic [NUM_LINES*STYLE_W-1:0] style_o,
  output logic [NUM_LINES-1:0]         status_o
);
  localparam int unsigned STY_REGS  = NUM_LINES / LINES_PER_REG;
  localparam int unsigned STY_REG_W = LINES_PER_REG * STYLE_W;

  logic [NUM_LINES-1:0] dir_q, out_q, status_q, clr;
  logic [STY_REG_W-1:0] style_q [STY_REGS];
  logic [DATA_W-1:0]    rd_val;
  logic                 wr_en, rd_en;

  assign wr_en = req_i & we_i;
  assign rd_en = req_i & ~we_i;
  assign clr   = (wr_en && addr_i == ADDR_W'(ADDR_STAT)) ? wdata_i[NUM_LINES-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q <= '1;
      out_q <= '0;
      for (int r = 0; r < STY_REGS; r++) style_q[r] <= {LINES_PER_REG{STY_OFF}};
    end else if (wr_en) begin
      if (addr_i == ADDR_W'(ADDR_DIR)) dir_q <= wdata_i[NUM_LINES-1:0];
      if (addr_i == ADDR_W'(ADDR_OUT)) out_q <= wdata_i[NUM_LINES-1:0];
      for (int r = 0; r < STY_REGS; r++)
        if (addr_i == ADDR_W'(ADDR_STY_BASE + r)) style_q[r] <= wdata_i[STY_REG_W-1:0];
    end
  end

  // events take priority over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= (status_q & ~clr) | ev_i;
  end

  always_comb begin
    rd_val = '0;
    if (addr_i == ADDR_W'(ADDR_DIR))  rd_val = DATA_W'(dir_q);
    if (addr_i == ADDR_W'(ADDR_OUT))  rd_val = DATA_W'(out_q);
    if (addr_i == ADDR_W'(ADDR_IN))   rd_val = DATA_W'(lvl_i);
    if (addr_i == ADDR_W'(ADDR_STAT)) rd_val = DATA_W'(status_q);
    for (int r = 0; r < STY_REGS; r++)
      if (addr_i == ADDR_W'(ADDR_STY_BASE + r)) rd_val = DATA_W'(style_q[r]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    rdata_o <= '0;
    else if (rd_en) rdata_o <= rd_val;
  end

  for (genvar r = 0; r < STY_REGS; r++) begin : g_sty
    assign style_o[r*STY_REG_W +: STY_REG_W] = style_q[r];
  end

  logic unused_wdata;
  assign unused_wdata = ^wdata_i;

  assign dir_o    = dir_q;
  assign out_o    = out_q;
  assign status_o = status_q;
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_LINES   = 16,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned ADDR_W      = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [DATA_W-1:0]    rdata_o,
  input  logic [NUM_LINES-1:0] pin_i,
  output logic [NUM_LINES-1:0] pin_o,
  output logic [NUM_LINES-1:0] pin_oe_o,
  output logic [NUM_LINES-1:0] irq_o
);
  logic [NUM_LINES-1:0]         lvl_sync, line_ev, dir, status;
  logic [NUM_LINES*STYLE_W-1:0] style;

  gpio_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pin_i), .q_o(lvl_sync)
  );

  gpio_detect #(.NUM_LINES(NUM_LINES)) u_det (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(lvl_sync), .style_i(style), .ev_o(line_ev)
  );

  gpio_regs #(.NUM_LINES(NUM_LINES), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .lvl_i(lvl_sync), .ev_i(line_ev),
    .dir_o(dir), .out_o(pin_o), .style_o(style), .status_o(status)
  );

  assign pin_oe_o = ~dir;
  assign irq_o    = status;
endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_LINES = 16,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 3
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 req_i,
  input logic                 we_i,
  input logic [ADDR_W-1:0]    addr_i,
  input logic [DATA_W-1:0]    wdata_i,
  input logic [DATA_W-1:0]    rdata_o,
  input logic [NUM_LINES-1:0] pin_o,
  input logic [NUM_LINES-1:0] pin_oe_o,
  input logic [NUM_LINES-1:0] irq_o,
  input logic [NUM_LINES-1:0] ev_i,
  input logic [NUM_LINES-1:0] lvl_i
);
  logic unused_w;
  assign unused_w = ^wdata_i;

  // R2
  dir_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == ADDR_W'(ADDR_DIR)) |=> (pin_oe_o == ~$past(wdata_i[NUM_LINES-1:0])));

  // R2
  out_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == ADDR_W'(ADDR_OUT)) |=> (pin_o == $past(wdata_i[NUM_LINES-1:0])));

  // R3
  in_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == ADDR_W'(ADDR_IN)) |=> (rdata_o == DATA_W'($past(lvl_i))));

  // R11
  event_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_i != '0) |=> ((irq_o & $past(ev_i)) == $past(ev_i)));

  // R10
  clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == ADDR_W'(ADDR_STAT))
      |=> ((irq_o & $past(wdata_i[NUM_LINES-1:0]) & ~$past(ev_i)) == '0));

  // R12
  irq_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((irq_o & ~$past(irq_o) & ~$past(ev_i)) == '0));
endmodule

bind gpio_irq_ctrl gpio_irq_chk #(.NUM_LINES(NUM_LINES), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .rdata_o(rdata_o), .pin_o(pin_o), .pin_oe_o(pin_oe_o),
  .irq_o(irq_o), .ev_i(line_ev), .lvl_i(lvl_sync)
);

// File: tb/sim_gpio_irq_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_irq_ctrl;
  localparam int N = 16;
  localparam logic [2:0] A_DIR = 3'd0, A_OUT = 3'd1, A_IN = 3'd2, A_STAT = 3'd3,
                         A_STY0 = 3'd4, A_STY1 = 3'd5;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req, we;
  logic [2:0]  addr;
  logic [31:0] wdata, rdata;
  logic [N-1:0] pins, pin_out, pin_oe, irq;
  logic [23:0] sty_shadow [2];
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  gpio_irq_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pin_i(pins), .pin_o(pin_out),
    .pin_oe_o(pin_oe), .irq_o(irq)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    req = 1'b1; we = 1'b0; addr = a;
    @(posedge clk);
    @(negedge clk);
    req = 1'b0;
    d = rdata;
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_style(int line, logic [2:0] code);
    sty_shadow[line / 8][(line % 8) * 3 +: 3] = code;
    wr((line < 8) ? A_STY0 : A_STY1, {8'h0, sty_shadow[line / 8]});
  endtask

  task automatic tidy();
    sty_shadow[0] = {8{3'd7}};
    sty_shadow[1] = {8{3'd7}};
    wr(A_STY0, {8'h0, sty_shadow[0]});
    wr(A_STY1, {8'h0, sty_shadow[1]});
    pins = '0;
    wait_n(4);
    wr(A_STAT, 32'hFFFF);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 oe after reset", 32'(pin_oe), 32'h0);
    chk("R1 pin_o after reset", 32'(pin_out), 32'h0);
    chk("R1 irq after reset", 32'(irq), 32'h0);
    rd(A_STY1, v);
    chk("R1 style reset", v, 32'h00FF_FFFF);
    rd(A_STAT, v);
    chk("R1 status reset", v, 32'h0);
  endtask

  task automatic t_direction();
    logic [31:0] v;
    wr(A_DIR, 32'h0000_00F0);
    chk("R2 oe from dir", 32'(pin_oe), 32'h0000_FF0F);
    wr(A_OUT, 32'h0000_A5C3);
    chk("R2 pin_o", 32'(pin_out), 32'h0000_A5C3);
    rd(A_DIR, v);
    chk("R2 dir readback", v, 32'h0000_00F0);
    rd(A_OUT, v);
    chk("R2 out readback", v, 32'h0000_A5C3);
    wr(A_DIR, 32'h0000_FFFF);
    chk("R2 all inputs", 32'(pin_oe), 32'h0);
  endtask

  task automatic t_input();
    logic [31:0] v;
    pins = 16'h1234;
    wait_n(4);
    pins = 16'hBEEF;
    rd(A_IN, v);
    rd(A_IN, v);
    chk("R3 second-edge read old", v, 32'h1234);
    rd(A_IN, v);
    chk("R3 third-edge read new", v, 32'hBEEF);
    pins = '0;
    wait_n(4);
  endtask

  task automatic t_rise();
    set_style(3, 3'd2);
    pins[3] = 1'b1;
    wait_n(2);
    chk("R4 not yet after two edges", 32'(irq), 32'h0);
    wait_n(1);
    chk("R4 rising sets on third edge", 32'(irq), 32'h0008);
    wr(A_STAT, 32'h0008);
    chk("R4 cleared", 32'(irq), 32'h0);
    pins[3] = 1'b0;
    wait_n(4);
    chk("R4 falling ignored", 32'(irq), 32'h0);
    tidy();
  endtask

  task automatic t_fall();
    pins[6] = 1'b1;
    wait_n(4);
    set_style(6, 3'd3);
    wait_n(4);
    chk("R5 no event while steady", 32'(irq), 32'h0);
    pins[6] = 1'b0;
    wait_n(3);
    chk("R5 falling sets", 32'(irq), 32'h0040);
    wr(A_STAT, 32'h0040);
    pins[6] = 1'b1;
    wait_n(4);
    chk("R5 rising ignored", 32'(irq), 32'h0);
    tidy();
  endtask

  task automatic t_both();
    set_style(10, 3'd4);
    pins[10] = 1'b1;
    wait_n(3);
    chk("R6 rise detected", 32'(irq), 32'h0400);
    wr(A_STAT, 32'h0400);
    pins[10] = 1'b0;
    wait_n(3);
    chk("R6 fall detected", 32'(irq), 32'h0400);
    tidy();
  endtask

  task automatic t_level_high();
    logic [31:0] v;
    set_style(5, 3'd0);
    pins[5] = 1'b1;
    wait_n(3);
    chk("R7 high sets", 32'(irq), 32'h0020);
    wr(A_STAT, 32'h0020);
    rd(A_STAT, v);
    chk("R7 clear blocked while high", v, 32'h0020);
    pins[5] = 1'b0;
    wait_n(4);
    chk("R7 sticky after drop", 32'(irq), 32'h0020);
    wr(A_STAT, 32'h0020);
    chk("R7 clear after drop", 32'(irq), 32'h0);
    tidy();
  endtask

  task automatic t_level_low();
    pins[9] = 1'b1;
    wait_n(4);
    set_style(9, 3'd1);
    wait_n(3);
    chk("R8 no event while high", 32'(irq), 32'h0);
    pins[9] = 1'b0;
    wait_n(3);
    chk("R8 low sets", 32'(irq), 32'h0200);
    wr(A_STAT, 32'h0200);
    chk("R8 clear blocked while low", 32'(irq), 32'h0200);
    pins[9] = 1'b1;
    wait_n(4);
    wr(A_STAT, 32'h0200);
    chk("R8 clear after rise", 32'(irq), 32'h0);
    tidy();
  endtask

  task automatic t_layout();
    set_style(4, 3'd2);
    pins[4] = 1'b1; pins[12] = 1'b1;
    wait_n(3);
    chk("R9 low register field pin 4 only", 32'(irq), 32'h0010);
    tidy();
    set_style(12, 3'd2);
    pins[4] = 1'b1; pins[12] = 1'b1;
    wait_n(3);
    chk("R9 high register field pin 12 only", 32'(irq), 32'h1000);
    tidy();
    set_style(0, 3'd5);
    set_style(1, 3'd6);
    set_style(2, 3'd7);
    pins[2:0] = 3'b111;
    wait_n(4);
    pins[2:0] = 3'b000;
    wait_n(4);
    chk("R9 codes 5 6 7 disabled", 32'(irq), 32'h0);
    tidy();
  endtask

  task automatic t_w1c();
    logic [31:0] v;
    set_style(7, 3'd2);
    set_style(14, 3'd2);
    pins[7] = 1'b1; pins[14] = 1'b1;
    wait_n(3);
    rd(A_STAT, v);
    chk("R10 status read", v, 32'h4080);
    chk("R12 irq mirrors status", 32'(irq), 32'h4080);
    wr(A_STAT, 32'h0080);
    rd(A_STAT, v);
    chk("R10 only written bit cleared", v, 32'h4000);
    wr(A_STAT, 32'h0000);
    rd(A_STAT, v);
    chk("R10 zero write no effect", v, 32'h4000);
    tidy();
  endtask

  task automatic t_race();
    set_style(11, 3'd2);
    pins[11] = 1'b1;
    wait_n(2);
    wr(A_STAT, 32'h0800);
    chk("R11 event wins over clear", 32'(irq), 32'h0800);
    tidy();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req = 1'b0; we = 1'b0; addr = '0; wdata = '0; pins = '0;
    sty_shadow[0] = {8{3'd7}};
    sty_shadow[1] = {8{3'd7}};
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);
    t_reset();
    t_direction();
    t_input();
    t_rise();
    t_fall();
    t_both();
    t_level_high();
    t_level_low();
    t_layout();
    t_w1c();
    t_race();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule